// File: doc/BRIEF.md
# Instruction Immediate Operand Generator

This block turns a raw 32-bit instruction word into the 64-bit immediate operand that an execution unit consumes. A 3-bit format selector, which an opcode decoder elsewhere drives, picks one of six ways of building the operand. There are two 16-bit forms, each zero- or sign-extended. There are two forms that place the 16-bit field in the upper half of a 32-bit value. There are two branch displacement forms, scaled to a byte offset by a factor of four and sign-extended.

Instruction words may arrive in either byte order. A byte-order input says whether the word is already in logical order or must be byte-reversed before any field is read. The same logical instruction therefore yields the same operand in both cases. The unit is purely combinational. The operand and its valid flag follow the inputs within the same cycle, with no handshake and no storage. A selector value that names no format gives a zero operand with the valid flag low.

Top module: `imm_gen`

## Requirements
- R1: With `imm_mode` = 0, `imm_value` equals logical instruction bits [15:0] with bits [63:16] zero.
- R2: With `imm_mode` = 1, `imm_value` equals logical bits [15:0] placed at [31:16], and bits [15:0] and [63:32] are zero.
- R3: With `imm_mode` = 2, `imm_value` equals logical bits [15:0] sign-extended from bit 15 to 64 bits.
- R4: With `imm_mode` = 3, `imm_value` equals logical bits [15:0] placed at [31:16], bits [15:0] zero, sign-extended from bit 31.
- R5: With `imm_mode` = 4, `imm_value` equals the 24-bit field at logical bits [25:2] times 4, sign-extended from logical bit 25.
- R6: With `imm_mode` = 5, `imm_value` equals the 14-bit field at logical bits [15:2] times 4, sign-extended from logical bit 15.
- R7: With `word_big_endian` = 1 the logical word is `insn_word` as given, with bit 31 as the most significant bit. With 0 the four bytes are reversed first: byte 0 (bits [7:0]) swaps with byte 3, and byte 1 swaps with byte 2. A logical instruction given in either order yields the same operand.
- R8: With `imm_mode` = 6 or 7, `imm_value` is zero and `imm_valid` is 0.
- R9: `imm_valid` is 1 for `imm_mode` 0 to 5. Both outputs depend only on the present inputs, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 32 | Raw instruction word as fetched |
| word_big_endian | input | 1 | 1: word already in logical order; 0: reverse its bytes first |
| imm_mode | input | 3 | Immediate format selector (0..5 valid) |
| imm_value | output | 64 | Generated immediate operand |
| imm_valid | output | 1 | High when `imm_mode` names a format |

## Verification
Each format is driven with field values at zero, at the largest positive value and at the most negative value. These show whether the sign comes from the right bit and whether the scaling shift and the zero padding sit where they should. Random words are then applied in every mode and in both byte orders. Each logical word is presented once as is and once byte-reversed, so a swap that reorders the wrong bytes, or is applied under the wrong polarity, shows up as a mismatch in every format. The two spare selector codes are driven with words full of ones, which exposes any leak of field bits into an operand that must be zero.

// File: rtl/imm_gen_pkg.sv
package imm_gen_pkg;

  typedef enum logic [2:0] {
    IMM_U_LO    = 3'd0,
    IMM_U_HI    = 3'd1,
    IMM_S_LO    = 3'd2,
    IMM_S_HI    = 3'd3,
    IMM_BR_LONG = 3'd4,
    IMM_BR_COND = 3'd5
  } imm_mode_e;

  localparam int NUM_FMT = 6;

  // Per-format field placement, indexed by the mode code.
  localparam int FMT_LO [NUM_FMT] = '{0, 0, 0, 0, 2, 2};
  localparam int FMT_W  [NUM_FMT] = '{16, 16, 16, 16, 24, 14};
  localparam int FMT_SH [NUM_FMT] = '{0, 16, 0, 16, 2, 2};
  localparam bit FMT_SX [NUM_FMT] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

endpackage

// File: rtl/imm_byte_order.sv
module imm_byte_order #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [WORD_W-1:0] raw,
  input  logic              keep_order,
  output logic [WORD_W-1:0] ordered
);
  localparam int NBYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] swapped;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[b*BYTE_W +: BYTE_W] = raw[(NBYTES-1-b)*BYTE_W +: BYTE_W];
  end

  assign ordered = keep_order ? raw : swapped;

  // R7: reordering moves bits but never creates or loses any
  always_comb begin
    a_r7_bits_preserved: assert ($countones(ordered) == $countones(raw));
  end

endmodule

// File: rtl/imm_field_extend.sv
module imm_field_extend #(
  parameter int WORD_W   = 32,
  parameter int DST_W    = 64,
  parameter int FIELD_LO = 0,
  parameter int FIELD_W  = 16,
  parameter int SCALE_SH = 0,
  parameter bit SIGN_EXT = 1'b0
) (
  input  logic [WORD_W-1:0] word,
  output logic [DST_W-1:0]  value
);
  localparam int SCALED_W = FIELD_W + SCALE_SH;
  localparam int PAD_W    = DST_W - SCALED_W;

  logic [FIELD_W-1:0]  field;
  logic [SCALED_W-1:0] scaled;
  logic                pad_bit;

  assign field  = FIELD_W'(word >> FIELD_LO);
  assign scaled = SCALED_W'(field) << SCALE_SH;

  if (SIGN_EXT) begin : g_signed
    assign pad_bit = scaled[SCALED_W-1];
  end else begin : g_unsigned
    assign pad_bit = 1'b0;
  end

  assign value = {{PAD_W{pad_bit}}, scaled};

  // R1 R2 R3 R4 R5 R6: the extracted field lands unchanged at its scaled place
  always_comb begin
    a_r3_field_placed: assert (value[SCALE_SH +: FIELD_W] == field);
  end

  // R3 R4 R5 R6: padding above the scaled value is uniform (zero when unsigned)
  always_comb begin
    a_r3_pad_uniform: assert (
      ($countones(value[DST_W-1:SCALED_W-1]) == 0) ||
      (SIGN_EXT && ($countones(value[DST_W-1:SCALED_W-1]) == PAD_W + 1)) ||
      (!SIGN_EXT && ($countones(value[DST_W-1:SCALED_W]) == 0)));
  end

endmodule

// File: rtl/imm_select.sv
module imm_select #(
  parameter int DST_W   = 64,
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [DST_W-1:0] cand [NUM_SRC],
  output logic [DST_W-1:0] value,
  output logic             valid
);

  always_comb begin
    valid = 1'b0;
    value = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) begin
        valid = 1'b1;
        value = cand[i];
      end
    end
  end

  // R8: an unnamed code never lets an operand through
  always_comb begin
    a_r8_invalid_zero: assert (valid || (value == '0));
  end

  // R9: validity tracks the selector range
  always_comb begin
    a_r9_valid_range: assert (valid == (int'(sel) < NUM_SRC));
  end

endmodule

// File: rtl/imm_gen.sv
module imm_gen
  import imm_gen_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int IMM_W  = 64,
  parameter int MODE_W = 3
) (
  input  logic [INSN_W-1:0] insn_word,
  input  logic              word_big_endian,
  input  logic [MODE_W-1:0] imm_mode,
  output logic [IMM_W-1:0]  imm_value,
  output logic              imm_valid
);
  localparam int BYTE_W = 8;

  logic [INSN_W-1:0] logical_word;
  logic [IMM_W-1:0]  cand [NUM_FMT];

  imm_byte_order #(
    .WORD_W (INSN_W),
    .BYTE_W (BYTE_W)
  ) u_order (
    .raw        (insn_word),
    .keep_order (word_big_endian),
    .ordered    (logical_word)
  );

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    imm_field_extend #(
      .WORD_W   (INSN_W),
      .DST_W    (IMM_W),
      .FIELD_LO (FMT_LO[g]),
      .FIELD_W  (FMT_W[g]),
      .SCALE_SH (FMT_SH[g]),
      .SIGN_EXT (FMT_SX[g])
    ) u_ext (
      .word  (logical_word),
      .value (cand[g])
    );
  end

  imm_select #(
    .DST_W   (IMM_W),
    .NUM_SRC (NUM_FMT),
    .SEL_W   (MODE_W)
  ) u_sel (
    .sel   (imm_mode),
    .cand  (cand),
    .value (imm_value),
    .valid (imm_valid)
  );

  // R1: zero-extended low form keeps nothing above bit 15
  always_comb begin
    a_r1_upper_clear: assert (!(imm_mode == MODE_W'(IMM_U_LO)) || (imm_value[IMM_W-1:16] == '0));
  end

  // R2: unsigned high form occupies only bits 31..16
  always_comb begin
    a_r2_window: assert (!(imm_mode == MODE_W'(IMM_U_HI)) ||
                         ((imm_value[15:0] == '0) && (imm_value[IMM_W-1:32] == '0)));
  end

  // R4: signed high form has a clear low half and uniform bits 63..31
  always_comb begin
    a_r4_high_shape: assert (!(imm_mode == MODE_W'(IMM_S_HI)) ||
                             ((imm_value[15:0] == '0) &&
                              (($countones(imm_value[IMM_W-1:31]) == 0) ||
                               ($countones(imm_value[IMM_W-1:31]) == IMM_W - 31))));
  end

  // R5 R6: branch displacements are whole-word byte offsets
  always_comb begin
    a_r5_word_aligned: assert (!((imm_mode == MODE_W'(IMM_BR_LONG)) ||
                                 (imm_mode == MODE_W'(IMM_BR_COND))) ||
                               (imm_value[1:0] == 2'b00));
  end

endmodule

// File: tb/imm_gen_test.sv
`timescale 1ns/1ps
module imm_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn_word = '0;
  logic        word_big_endian = 1'b1;
  logic [2:0]  imm_mode = 3'd7;
  logic [63:0] imm_value;
  logic        imm_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  imm_gen uut (
    .insn_word       (insn_word),
    .word_big_endian (word_big_endian),
    .imm_mode        (imm_mode),
    .imm_value       (imm_value),
    .imm_valid       (imm_valid)
  );

  function automatic logic [31:0] swap_bytes(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic string tag_of(int mode);
    case (mode)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // Behavioural model of the operand, from the logical word.
  function automatic longint ref_imm(logic [31:0] w, int mode);
    longint s;
    case (mode)
      0: return longint'(w[15:0]);
      1: return longint'(w[15:0]) * 65536;
      2: begin
        s = longint'(w[15:0]);
        if (w[15]) s = s - 65536;
        return s;
      end
      3: begin
        s = longint'(w[15:0]);
        if (w[15]) s = s - 65536;
        return s * 65536;
      end
      4: begin
        s = longint'(w[25:2]);
        if (w[25]) s = s - 64'sd16777216;
        return s * 4;
      end
      5: begin
        s = longint'(w[15:2]);
        if (w[15]) s = s - 16384;
        return s * 4;
      end
      default: return 0;
    endcase
  endfunction

  task automatic apply(logic [31:0] logical, int mode, bit big);
    longint exp_v;
    bit     exp_ok;
    @(posedge clk);
    #1;
    insn_word       = big ? logical : swap_bytes(logical);
    word_big_endian = big;
    imm_mode        = 3'(mode);
    exp_v  = ref_imm(logical, mode);
    exp_ok = (mode < 6);
    @(negedge clk);
    checks++;
    if ((imm_value !== 64'(exp_v)) || (imm_valid !== exp_ok)) begin
      errors++;
      $display("FAIL %s%s mode=%0d big=%0b word=%h value got %h exp %h valid got %b exp %b",
               tag_of(mode), big ? "" : "/R7", mode, big, logical,
               imm_value, 64'(exp_v), imm_valid, exp_ok);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time state, spare code: R8
    apply(32'hFFFF_FFFF, 7, 1'b1);
    apply(32'hFFFF_FFFF, 6, 1'b0);
    // R9 and every format at corners, in both byte orders (R7)
    for (int be = 0; be < 2; be++) begin
      for (int m = 0; m < 6; m++) begin
        apply(32'h0000_0000, m, bit'(be));
        apply(32'h0000_7FFF, m, bit'(be));   // R3 R4 largest positive
        apply(32'h0000_8000, m, bit'(be));   // R3 R4 R6 most negative
        apply(32'hFFFF_FFFF, m, bit'(be));
        apply(32'h01FF_FFFC, m, bit'(be));   // R5 most positive displacement
        apply(32'h0200_0000, m, bit'(be));   // R5 most negative displacement
        apply(32'hFC00_0003, m, bit'(be));   // R5 bits outside field set
        apply(32'h0000_7FFC, m, bit'(be));   // R6 most positive
      end
    end
    // random words, every code, both orders
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      w = $urandom;
      for (int m = 0; m < 8; m++) begin
        apply(w, m, 1'b1);
        apply(w, m, 1'b0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule